// File: doc/BRIEF.md
# Configurable Pixel Capture Adapter

This block sits behind a parallel video input and turns whatever bus shape the graphics source uses into a uniform stream of 24-bit pixels. Each pixel carries its own horizontal sync, vertical sync and data-enable flags. The incoming pixel clock also clocks the internal side of the block. Inputs are taken on the rising edge, the falling edge or both, through separate rising-edge and falling-edge capture registers. Everything is then retimed onto the rising edge. The output is two pixel lanes with a valid bit each, because some legal modes deliver two pixels per clock period.

A static configuration picks how the bus is read. Half-pixel mode rebuilds one pixel from two 12-bit halves on consecutive edges. Full-pixel modes take one 18-bit or 24-bit pixel per edge. Double-pixel modes take two pixels side by side on one edge. The 18-bit pixels are widened to 24 bits by padding each colour component with zeros. Configurations that make no sense raise a sticky error flag and silence the output.

Top module: `pxcap_top`

## Requirements
- R1: While reset is asserted and after it is released, with no edge yet sampled, `pix_valid` is 0 and `config_error` is 0. Any reset clears a previously raised `config_error`.
- R2: With `cfg_mode`=2 (24-bit full) and `cfg_edge`=0 (rising), the bus bits [23:0] and flags present at rising edge k appear on lane 0 after rising edge k+1, with `pix_valid`=2'b01. The flag encoding is bit0 data enable, bit1 horizontal sync, bit2 vertical sync.
- R3: With `cfg_edge`=1 (falling), the bus value sampled at the falling edge that follows rising edge k appears on lane 0 after rising edge k+1, with `pix_valid`=2'b01.
- R4: With a full-pixel mode and `cfg_edge`=2 (both), `pix_valid`=2'b11 every cycle and lane 0 holds the earlier edge. With `cfg_fall_first`=0, lane 0 is rising edge k and lane 1 is the falling edge after it. With `cfg_fall_first`=1, lane 0 is the falling edge before rising edge k and lane 1 is rising edge k.
- R5: With `cfg_mode`=1 (18-bit full), the three 6-bit components at bus [5:0], [11:6] and [17:12] go to output bits [7:2], [15:10] and [23:18]. Bits [1:0], [9:8] and [17:16] are zero.
- R6: With `cfg_mode`=4 (48-bit double) and a single edge, bus [23:0] goes to lane 0 (pixel n) and bus [47:24] goes to lane 1 (pixel n+1). Both lanes carry the flags from the same edge, with `pix_valid`=2'b11.
- R7: With `cfg_mode`=3 (36-bit double), bus [17:0] goes to lane 0 and bus [35:18] goes to lane 1, each widened as in R5.
- R8: With `cfg_mode`=0 (12-bit half) and `cfg_fall_first`=0, one pixel per cycle is produced. Its low 12 bits come from bus [11:0] at rising edge k and its high 12 bits from bus [11:0] at the following falling edge. The flags come from the low-half edge.
- R9: With `cfg_mode`=0 and `cfg_fall_first`=1, the low half comes from the falling edge before rising edge k and the high half from rising edge k.
- R10: A configuration is illegal when the mode code is above 4, the edge code is 3, half-pixel mode uses a single edge, or a double-pixel mode uses both edges. An illegal configuration sets `config_error` at the next rising edge and keeps `pix_valid` at 0.
- R11: Once set, `config_error` stays set and `pix_valid` stays 0 even after a legal configuration is applied, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| px_clk | input | 1 | Pixel clock, also the internal clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_mode | input | 3 | 0 half 12-bit, 1 full 18-bit, 2 full 24-bit, 3 double 36-bit, 4 double 48-bit |
| cfg_edge | input | 2 | 0 rising, 1 falling, 2 both |
| cfg_fall_first | input | 1 | Falling edge leads in both-edge pairing |
| vid_bus | input | 48 | Parallel pixel data |
| vid_hsync | input | 1 | Horizontal sync framing |
| vid_vsync | input | 1 | Vertical sync framing |
| vid_de | input | 1 | Data enable framing |
| pix_valid | output | 2 | Lane valid bits, bit0 lane 0, bit1 lane 1 |
| pix0_rgb | output | 24 | Lane 0 pixel (earlier pixel) |
| pix0_flags | output | 3 | Lane 0 flags {vsync, hsync, de} |
| pix1_rgb | output | 24 | Lane 1 pixel (later pixel) |
| pix1_flags | output | 3 | Lane 1 flags {vsync, hsync, de} |
| config_error | output | 1 | Sticky illegal-configuration flag |

## Verification
In one output cycle the block can merge a falling-edge sample with a rising-edge sample. In the falling-first order, the falling sample is one that was taken a full period earlier. The bench drives distinct data, with distinct flags, on every rising and every falling edge. It then requires each lane to show exactly the edge that R4, R8 and R9 assign to it, so any mix-up of current and delayed falling samples is caught.

Error detection also falls in the same cycle as pixel emission. The bench switches to an illegal pairing while data keeps streaming. It then requires that the next output cycle already has no valid lanes and a raised error flag, and that this holds after a legal setting returns.

// File: rtl/pxcap_pkg.sv
package pxcap_pkg;
  localparam int COMP_W   = 8;
  localparam int NARROW_W = 6;
  localparam int NCOMP    = 3;
  localparam int FLAG_W   = 3;
  localparam int PIX_W    = COMP_W * NCOMP;
  localparam int NPIX_W   = NARROW_W * NCOMP;
  localparam int HALF_W   = PIX_W / 2;
  localparam int BUS_W    = 2 * PIX_W;
  localparam int PAD_W    = COMP_W - NARROW_W;

  localparam logic [2:0] MODE_HALF12 = 3'd0;
  localparam logic [2:0] MODE_FULL18 = 3'd1;
  localparam logic [2:0] MODE_FULL24 = 3'd2;
  localparam logic [2:0] MODE_DBL36  = 3'd3;
  localparam logic [2:0] MODE_DBL48  = 3'd4;

  localparam logic [1:0] EDGE_RISE = 2'd0;
  localparam logic [1:0] EDGE_FALL = 2'd1;
  localparam logic [1:0] EDGE_BOTH = 2'd2;

  typedef struct packed {
    logic [BUS_W-1:0]  data;
    logic [FLAG_W-1:0] flags;
  } edge_sample_t;

  // Place each narrow component in the top of its wide field, zero-padded below.
  function automatic logic [PIX_W-1:0] widen(input logic [NPIX_W-1:0] n);
    logic [PIX_W-1:0] w;
    w = '0;
    for (int c = 0; c < NCOMP; c++) begin
      w[c*COMP_W + PAD_W +: NARROW_W] = n[c*NARROW_W +: NARROW_W];
    end
    return w;
  endfunction

  function automatic logic [PIX_W-1:0] fit(input logic [PIX_W-1:0] x, input logic narrow);
    return narrow ? widen(x[NPIX_W-1:0]) : x;
  endfunction
endpackage

// File: rtl/pxcap_cfgchk.sv
module pxcap_cfgchk
  import pxcap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode,
  input  logic [1:0] edge_sel,
  output logic       legal,
  output logic       err_q
);
  logic err_n;

  always_comb begin
    legal = 1'b1;
    if (mode > MODE_DBL48) legal = 1'b0;
    if (edge_sel == 2'd3) legal = 1'b0;
    if (mode == MODE_HALF12 && edge_sel != EDGE_BOTH) legal = 1'b0;
    if ((mode == MODE_DBL36 || mode == MODE_DBL48) && edge_sel == EDGE_BOTH) legal = 1'b0;
    err_n = err_q | ~legal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_n;
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q); // R11

  AST_ILLEGAL_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    !legal |=> err_q); // R10
endmodule

// File: rtl/pxcap_capture.sv
module pxcap_capture
  import pxcap_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rise_en,
  input  logic         fall_en,
  input  edge_sample_t din,
  output edge_sample_t rise_q,
  output edge_sample_t fall_q,
  output edge_sample_t fall_d
);
  edge_sample_t rise_n, fall_n, falld_n;

  always_comb begin
    rise_n  = rise_en ? din    : rise_q;
    fall_n  = fall_en ? din    : fall_q;
    falld_n = fall_en ? fall_q : fall_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rise_q <= '0;
    else        rise_q <= rise_n;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fall_q <= '0;
    else        fall_q <= fall_n;
  end

  // Retime the falling sample by one rising edge for falling-first pairing.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fall_d <= '0;
    else        fall_d <= falld_n;
  end
endmodule

// File: rtl/pxcap_assemble.sv
module pxcap_assemble
  import pxcap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode,
  input  logic [1:0]        edge_sel,
  input  logic              fall_first,
  input  logic              legal,
  input  logic              err_q,
  input  edge_sample_t      rise_s,
  input  edge_sample_t      fall_s,
  input  edge_sample_t      fall_d,
  output logic [1:0]        valid,
  output logic [PIX_W-1:0]  p0,
  output logic [FLAG_W-1:0] f0,
  output logic [PIX_W-1:0]  p1,
  output logic [FLAG_W-1:0] f1
);
  edge_sample_t      src, first, second;
  logic              narrow;
  logic [1:0]        v_n;
  logic [PIX_W-1:0]  p0_n, p1_n;
  logic [FLAG_W-1:0] f0_n, f1_n;

  always_comb begin
    src    = (edge_sel == EDGE_FALL) ? fall_s : rise_s;
    first  = fall_first ? fall_d : rise_s;
    second = fall_first ? rise_s : fall_s;
    narrow = (mode == MODE_FULL18) || (mode == MODE_DBL36);
    v_n = '0; p0_n = '0; p1_n = '0; f0_n = '0; f1_n = '0;
    case (mode)
      MODE_HALF12: begin
        p0_n = {second.data[HALF_W-1:0], first.data[HALF_W-1:0]};
        f0_n = first.flags;
        v_n  = 2'b01;
      end
      MODE_FULL18, MODE_FULL24: begin
        if (edge_sel == EDGE_BOTH) begin
          p0_n = fit(first.data[PIX_W-1:0], narrow);
          f0_n = first.flags;
          p1_n = fit(second.data[PIX_W-1:0], narrow);
          f1_n = second.flags;
          v_n  = 2'b11;
        end else begin
          p0_n = fit(src.data[PIX_W-1:0], narrow);
          f0_n = src.flags;
          v_n  = 2'b01;
        end
      end
      MODE_DBL36: begin
        p0_n = widen(src.data[NPIX_W-1:0]);
        p1_n = widen(src.data[2*NPIX_W-1:NPIX_W]);
        f0_n = src.flags;
        f1_n = src.flags;
        v_n  = 2'b11;
      end
      MODE_DBL48: begin
        p0_n = src.data[PIX_W-1:0];
        p1_n = src.data[BUS_W-1:PIX_W];
        f0_n = src.flags;
        f1_n = src.flags;
        v_n  = 2'b11;
      end
      default: v_n = '0;
    endcase
    if (!legal || err_q) v_n = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= '0; p0 <= '0; f0 <= '0; p1 <= '0; f1 <= '0;
    end else begin
      valid <= v_n; p0 <= p0_n; f0 <= f0_n; p1 <= p1_n; f1 <= f1_n;
    end
  end

  AST_HALF_SINGLE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_HALF12 && $stable(mode) && valid != 2'b00) |-> valid == 2'b01); // R8

  AST_NARROW_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_FULL18 && $stable(mode) && valid[0])
      |-> (p0[1:0] == 2'b00 && p0[9:8] == 2'b00 && p0[17:16] == 2'b00)); // R5

  AST_LANE1_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
    valid[1] |-> valid[0]); // R4
endmodule

// File: rtl/pxcap_top.sv
module pxcap_top
  import pxcap_pkg::*;
(
  input  logic              px_clk,
  input  logic              rst_n,
  input  logic [2:0]        cfg_mode,
  input  logic [1:0]        cfg_edge,
  input  logic              cfg_fall_first,
  input  logic [BUS_W-1:0]  vid_bus,
  input  logic              vid_hsync,
  input  logic              vid_vsync,
  input  logic              vid_de,
  output logic [1:0]        pix_valid,
  output logic [PIX_W-1:0]  pix0_rgb,
  output logic [FLAG_W-1:0] pix0_flags,
  output logic [PIX_W-1:0]  pix1_rgb,
  output logic [FLAG_W-1:0] pix1_flags,
  output logic              config_error
);
  edge_sample_t din, rise_s, fall_s, fall_d;
  logic         legal, err_q, rise_en, fall_en;

  always_comb begin
    din.data  = vid_bus;
    din.flags = {vid_vsync, vid_hsync, vid_de};
    rise_en   = (cfg_edge != EDGE_FALL);
    fall_en   = (cfg_edge != EDGE_RISE);
  end

  pxcap_cfgchk u_cfg (
    .clk(px_clk), .rst_n(rst_n), .mode(cfg_mode), .edge_sel(cfg_edge),
    .legal(legal), .err_q(err_q)
  );

  pxcap_capture u_cap (
    .clk(px_clk), .rst_n(rst_n), .rise_en(rise_en), .fall_en(fall_en),
    .din(din), .rise_q(rise_s), .fall_q(fall_s), .fall_d(fall_d)
  );

  pxcap_assemble u_asm (
    .clk(px_clk), .rst_n(rst_n), .mode(cfg_mode), .edge_sel(cfg_edge),
    .fall_first(cfg_fall_first), .legal(legal), .err_q(err_q),
    .rise_s(rise_s), .fall_s(fall_s), .fall_d(fall_d),
    .valid(pix_valid), .p0(pix0_rgb), .f0(pix0_flags), .p1(pix1_rgb), .f1(pix1_flags)
  );

  assign config_error = err_q;

  AST_NO_VALID_ON_ERROR: assert property (@(posedge px_clk) disable iff (!rst_n)
    config_error |-> pix_valid == 2'b00); // R10
endmodule

// File: tb/pxcap_top_bench.sv
module pxcap_top_bench;
  logic        clk;
  logic        rst_n;
  logic [2:0]  cfg_mode;
  logic [1:0]  cfg_edge;
  logic        cfg_fall_first;
  logic [47:0] vid_bus;
  logic        vid_hsync, vid_vsync, vid_de;
  logic [1:0]  pix_valid;
  logic [23:0] pix0_rgb, pix1_rgb;
  logic [2:0]  pix0_flags, pix1_flags;
  logic        config_error;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam int N = 16;
  logic [47:0] rd [N];
  logic [47:0] fd [N];
  logic [2:0]  rfl [N];
  logic [2:0]  ffl [N];

  pxcap_top u_pxcap_top (
    .px_clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_edge(cfg_edge),
    .cfg_fall_first(cfg_fall_first), .vid_bus(vid_bus), .vid_hsync(vid_hsync),
    .vid_vsync(vid_vsync), .vid_de(vid_de), .pix_valid(pix_valid),
    .pix0_rgb(pix0_rgb), .pix0_flags(pix0_flags), .pix1_rgb(pix1_rgb),
    .pix1_flags(pix1_flags), .config_error(config_error)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] pad18(input logic [17:0] x);
    return {x[17:12], 2'b00, x[11:6], 2'b00, x[5:0], 2'b00};
  endfunction

  task automatic drive(input logic [47:0] d, input logic [2:0] fl);
    vid_bus = d; vid_de = fl[0]; vid_hsync = fl[1]; vid_vsync = fl[2];
  endtask

  task automatic gen(input logic [7:0] seed);
    for (int k = 0; k < N; k++) begin
      rd[k]  = {seed, 8'(k), 32'(k * 32'h9E37_79B9 + 32'h0F0F_1234)};
      fd[k]  = {~seed, 8'(k + 8'h80), 32'(k * 32'h7F4A_7C15 + 32'hC0DE_0001)};
      rfl[k] = 3'(k);
      ffl[k] = 3'(k + 3);
    end
  endtask

  // Stream N cycles; after rising edge k compare the outputs built from edges k-1.
  task automatic stream(input logic [2:0] m, input logic [1:0] e, input bit ffirst,
                        input logic [7:0] seed, input string req);
    logic [1:0]  ev;
    logic [23:0] ep0, ep1;
    logic [2:0]  ef0, ef1;
    logic [47:0] rv, fv, fdv;
    logic [2:0]  rf, ff, fdf;
    gen(seed);
    cfg_mode = m; cfg_edge = e; cfg_fall_first = ffirst;
    for (int k = 0; k < N; k++) begin
      @(negedge clk); #1;
      drive(rd[k], rfl[k]);
      @(posedge clk); #1;
      if (k >= 2) begin
        rv = rd[k-1]; rf = rfl[k-1];
        fv = fd[k-1]; ff = ffl[k-1];
        fdv = fd[k-2]; fdf = ffl[k-2];
        ep1 = '0; ef1 = '0;
        case (m)
          3'd0: begin
            ev = 2'b01;
            if (!ffirst) begin ep0 = {fv[11:0], rv[11:0]}; ef0 = rf; end
            else         begin ep0 = {rv[11:0], fdv[11:0]}; ef0 = fdf; end
          end
          3'd1, 3'd2: begin
            if (e == 2'd2) begin
              ev = 2'b11;
              if (!ffirst) begin ep0 = rv[23:0]; ef0 = rf; ep1 = fv[23:0]; ef1 = ff; end
              else         begin ep0 = fdv[23:0]; ef0 = fdf; ep1 = rv[23:0]; ef1 = rf; end
            end else begin
              ev = 2'b01;
              ep0 = (e == 2'd1) ? fv[23:0] : rv[23:0];
              ef0 = (e == 2'd1) ? ff : rf;
            end
            if (m == 3'd1) begin ep0 = pad18(ep0[17:0]); ep1 = pad18(ep1[17:0]); end
          end
          3'd3: begin
            ev = 2'b11;
            ep0 = pad18((e == 2'd1) ? fv[17:0] : rv[17:0]);
            ep1 = pad18((e == 2'd1) ? fv[35:18] : rv[35:18]);
            ef0 = (e == 2'd1) ? ff : rf; ef1 = ef0;
          end
          default: begin
            ev = 2'b11;
            ep0 = (e == 2'd1) ? fv[23:0] : rv[23:0];
            ep1 = (e == 2'd1) ? fv[47:24] : rv[47:24];
            ef0 = (e == 2'd1) ? ff : rf; ef1 = ef0;
          end
        endcase
        check(pix_valid == ev, req, 64'(pix_valid), 64'(ev));
        check(pix0_rgb == ep0 && pix0_flags == ef0, req, {37'd0, pix0_flags, pix0_rgb}, {37'd0, ef0, ep0});
        if (ev[1])
          check(pix1_rgb == ep1 && pix1_flags == ef1, req, {37'd0, pix1_flags, pix1_rgb}, {37'd0, ef1, ep1});
      end
      drive(fd[k], ffl[k]);
    end
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(pix_valid == 2'b00, "R1", 64'(pix_valid), 64'd0);
    check(config_error == 1'b0, "R1", 64'(config_error), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset;
    cfg_mode = 3'd2; cfg_edge = 2'd0; cfg_fall_first = 1'b0;
    drive('0, 3'b000);
    do_reset();
    #0.5;
    check(pix_valid == 2'b00, "R1", 64'(pix_valid), 64'd0);
  endtask

  task automatic t_full;
    stream(3'd2, 2'd0, 1'b0, 8'h21, "R2");
    stream(3'd2, 2'd1, 1'b0, 8'h32, "R3");
    stream(3'd2, 2'd2, 1'b0, 8'h43, "R4");
    stream(3'd2, 2'd2, 1'b1, 8'h54, "R4");
    stream(3'd1, 2'd0, 1'b0, 8'h65, "R5");
    stream(3'd1, 2'd2, 1'b1, 8'h76, "R5");
  endtask

  task automatic t_double;
    stream(3'd4, 2'd0, 1'b0, 8'h87, "R6");
    stream(3'd4, 2'd1, 1'b1, 8'h98, "R6");
    stream(3'd3, 2'd1, 1'b0, 8'hA9, "R7");
    stream(3'd3, 2'd0, 1'b0, 8'hBA, "R7");
  endtask

  task automatic t_half;
    stream(3'd0, 2'd2, 1'b0, 8'hCB, "R8");
    stream(3'd0, 2'd2, 1'b1, 8'hDC, "R9");
  endtask

  task automatic t_illegal;
    // double width with both edges while data keeps changing
    @(posedge clk); #1;
    cfg_mode = 3'd4; cfg_edge = 2'd2; cfg_fall_first = 1'b0;
    drive(48'hFFFF_0000_AAAA, 3'b111);
    @(posedge clk); #1;
    check(config_error == 1'b1, "R10", 64'(config_error), 64'd1);
    check(pix_valid == 2'b00, "R10", 64'(pix_valid), 64'd0);
    // legal setting again: the error must persist
    cfg_mode = 3'd2; cfg_edge = 2'd0;
    repeat (3) @(posedge clk);
    #1;
    check(config_error == 1'b1, "R11", 64'(config_error), 64'd1);
    check(pix_valid == 2'b00, "R11", 64'(pix_valid), 64'd0);
    do_reset();
    // half width on one edge only
    @(posedge clk); #1;
    cfg_mode = 3'd0; cfg_edge = 2'd0;
    @(posedge clk); #1;
    check(config_error == 1'b1, "R10", 64'(config_error), 64'd1);
    check(pix_valid == 2'b00, "R10", 64'(pix_valid), 64'd0);
    // reserved edge code
    cfg_mode = 3'd2; cfg_edge = 2'd2;
    do_reset();
    @(posedge clk); #1;
    cfg_edge = 2'd3;
    @(posedge clk); #1;
    check(config_error == 1'b1, "R10", 64'(config_error), 64'd1);
    cfg_edge = 2'd0;
    do_reset();
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    t_reset();
    t_full();
    t_double();
    t_half();
    t_illegal();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule